// File: doc/BRIEF.md
# Auto-Acknowledging Priority Interrupt Controller

This block gathers level-sensitive interrupt lines from the rest of the chip and offers them to a small set of CPUs. Each source has one mask bit and one software trigger bit, and the trigger is ORed with the hardware line to form the source's pending state. Every source also carries a routing field with one bit per CPU, which selects the CPUs that may take it. Each CPU has two inter-processor interrupts of its own, and the two behave the same way.

A CPU services interrupts by reading its own event register. One read returns the winning event and acknowledges it. An IPI is cleared by that read. A hardware source has its mask bit set in the same cycle, so software does not need a second access, and it unmasks the source when it has finished servicing it. IPIs win over hardware sources. Among hardware sources, the lowest number wins. Each CPU has an interrupt output that is formed combinationally from the registered state and stays high while that CPU has anything to collect.

The register bus uses word addresses. It has one write strobe and one read strobe, and the two never fire in the same cycle. Read data is registered and appears the cycle after the read strobe. Hardware lines pass through one input register before they count as pending.

Top module: `autoack_irq_ctrl`

## Requirements
- R1: After reset all mask bits are 1 and all software triggers and IPIs are 0. Every routing field is 1, which routes the source to CPU 0 only. The interrupt outputs and read data are 0.
- R2: A source is pending when its registered hardware line or its software trigger is 1. Writing word 5 sets the software triggers whose bits are 1, and writing word 6 clears them. Bits written as 0 leave their triggers unchanged. Word 4 reads the triggers and word 8 reads the pending vector.
- R3: Writing word 1 sets mask bits and writing word 2 clears them, in both cases only where the written bit is 1. Word 0 reads the mask. A masked source neither raises an interrupt output nor wins an event read.
- R4: The output irq_o[c] is 1 exactly when an unmasked pending source is routed to CPU c, or when one of CPU c's IPIs is pending.
- R5: A read of word 16+c returns CPU c's event. For a hardware winner, bits 18:16 hold 1 and bits 15:0 hold the lowest-numbered unmasked pending source routed to CPU c.
- R6: An event read that delivers a hardware source sets that source's mask bit. No other mask bit changes.
- R7: Writing word 24+c with bit 0 or bit 1 set makes IPI 0 or IPI 1 of CPU c pending. IPIs win over hardware sources, and IPI 0 wins over IPI 1. An IPI event has 2 in bits 18:16 and the IPI number in bits 15:0, and the read that returns it clears it.
- R8: An event read with nothing eligible returns 0 and changes no mask bit and no IPI.
- R9: Word 32+s holds the routing field of source s, where bit c allows CPU c. A source is eligible only for the CPUs whose bit is set.
- R10: While a hardware line stays high, its source stays pending. Once the source is acknowledged and then unmasked, it raises the interrupt again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after bus_rd |
| hw_irq | input | NUM_SRC | Level-sensitive hardware interrupt lines |
| irq_o | output | NUM_CPU | Interrupt request to each CPU |

## Verification
The assertions are checked on every cycle. They confirm that an acknowledge hits at most one source and sets that source's mask bit. They confirm that an acknowledged IPI is gone in the next cycle and that an IPI acknowledge never also acknowledges a hardware source. They also confirm that a read with nothing to deliver leaves masks and IPIs untouched. Some properties only the bench scenarios can show. These are the order in which events are drained for a given pattern, the routing of sources across CPUs, the re-firing of a held line after unmasking, and the exact encoding of the event word. The bench checks them against a model of masks, triggers, routing and IPIs.

// File: rtl/aic_pkg.sv
package aic_pkg;
  // event word: kind in bits [KIND_LSB+2:KIND_LSB], number in [15:0]
  localparam int KIND_LSB    = 16;
  localparam int IPI_PER_CPU = 2;

  typedef enum logic [2:0] {
    EVT_NONE = 3'd0,
    EVT_HW   = 3'd1,
    EVT_IPI  = 3'd2
  } evt_kind_e;

  // word addresses
  localparam int A_MASK     = 0;
  localparam int A_MASK_SET = 1;
  localparam int A_MASK_CLR = 2;
  localparam int A_SW       = 4;
  localparam int A_SW_SET   = 5;
  localparam int A_SW_CLR   = 6;
  localparam int A_PEND     = 8;
  localparam int A_EVT_BASE = 16;
  localparam int A_IPI_BASE = 24;
  localparam int A_AFF_BASE = 32;
endpackage

// File: rtl/aic_pick.sv
// Lowest-index-wins picker over a request vector.
module aic_pick #(
  parameter int W  = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  grant
);
  always_comb begin
    found = |req;
    idx   = '0;
    grant = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx      = IW'(i);
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/aic_src_regs.sv
// Per-source state: input register, mask, software trigger, CPU routing.
module aic_src_regs #(
  parameter int NUM_SRC   = 16,
  parameter int NUM_CPU   = 2,
  parameter int AFF_RESET = 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_SRC-1:0]                hw_irq,
  input  logic [NUM_SRC-1:0]                mask_set,
  input  logic [NUM_SRC-1:0]                mask_clr,
  input  logic [NUM_SRC-1:0]                sw_set,
  input  logic [NUM_SRC-1:0]                sw_clr,
  input  logic [NUM_SRC-1:0]                aff_we,
  input  logic [NUM_CPU-1:0]                aff_wdata,
  input  logic [NUM_SRC-1:0]                ack_vec,
  output logic [NUM_SRC-1:0]                mask_q,
  output logic [NUM_SRC-1:0]                sw_q,
  output logic [NUM_SRC-1:0]                pend,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]   aff_q,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   elig
);
  logic [NUM_SRC-1:0] hw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_q   <= '0;
      mask_q <= '1;
      sw_q   <= '0;
    end else begin
      hw_q   <= hw_irq;
      mask_q <= (mask_q | mask_set | ack_vec) & ~mask_clr;
      sw_q   <= (sw_q | sw_set) & ~sw_clr;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_aff
    always_ff @(posedge clk) begin
      if (rst)            aff_q[s] <= NUM_CPU'(AFF_RESET);
      else if (aff_we[s]) aff_q[s] <= aff_wdata;
    end
  end

  assign pend = hw_q | sw_q;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++)
      for (int s = 0; s < NUM_SRC; s++)
        elig[c][s] = pend[s] & ~mask_q[s] & aff_q[s][c];
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_vec)); // R5
  AST_ACK_MASKS: assert property (@(posedge clk) disable iff (rst)
    (ack_vec != '0) |=> ((mask_q & $past(ack_vec)) == $past(ack_vec))); // R6
endmodule

// File: rtl/aic_ipi_bank.sv
// Two inter-processor interrupt flags per CPU.
module aic_ipi_bank #(
  parameter int NUM_CPU = 2,
  parameter int NUM_IPI = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_CPU-1:0][NUM_IPI-1:0] ipi_set,
  input  logic [NUM_CPU-1:0][NUM_IPI-1:0] ipi_ack,
  output logic [NUM_CPU-1:0][NUM_IPI-1:0] ipi_q
);
  always_ff @(posedge clk) begin
    if (rst) ipi_q <= '0;
    else     ipi_q <= (ipi_q | ipi_set) & ~ipi_ack;
  end

  AST_IPI_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ipi_ack != '0) |=> ((ipi_q & $past(ipi_ack)) == '0)); // R7
endmodule

// File: rtl/autoack_irq_ctrl.sv
module autoack_irq_ctrl
  import aic_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] hw_irq,
  output logic [NUM_CPU-1:0] irq_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] wsrc;
  logic [NUM_SRC-1:0] mask_set, mask_clr, sw_set, sw_clr, aff_we, ack_vec;
  logic [NUM_SRC-1:0] mask_q, sw_q, pend;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] aff_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] elig, hw_grant, ack_part;
  logic [NUM_CPU-1:0][IPI_PER_CPU-1:0] ipi_set, ipi_ack, ipi_q;
  logic [NUM_CPU-1:0] evt_sel, hw_found;
  logic [IDX_W-1:0]   hw_idx [NUM_CPU];
  logic [DATA_W-1:0]  evt_word [NUM_CPU];
  logic [DATA_W-1:0]  rd_next;
  logic               unused_bits;

  assign wsrc        = bus_wdata[NUM_SRC-1:0];
  assign unused_bits = ^bus_wdata;

  // write decode
  always_comb begin
    mask_set = '0;
    mask_clr = '0;
    sw_set   = '0;
    sw_clr   = '0;
    if (bus_wr) begin
      if (bus_addr == ADDR_W'(A_MASK_SET)) mask_set = wsrc;
      if (bus_addr == ADDR_W'(A_MASK_CLR)) mask_clr = wsrc;
      if (bus_addr == ADDR_W'(A_SW_SET))   sw_set   = wsrc;
      if (bus_addr == ADDR_W'(A_SW_CLR))   sw_clr   = wsrc;
    end
    for (int s = 0; s < NUM_SRC; s++)
      aff_we[s] = bus_wr && (bus_addr == ADDR_W'(A_AFF_BASE + s));
    for (int c = 0; c < NUM_CPU; c++) begin
      ipi_set[c] = (bus_wr && bus_addr == ADDR_W'(A_IPI_BASE + c))
                   ? bus_wdata[IPI_PER_CPU-1:0] : '0;
      evt_sel[c] = bus_rd && (bus_addr == ADDR_W'(A_EVT_BASE + c));
    end
  end

  aic_src_regs #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .AFF_RESET(1)
  ) u_src (
    .clk(clk), .rst(rst), .hw_irq(hw_irq),
    .mask_set(mask_set), .mask_clr(mask_clr),
    .sw_set(sw_set), .sw_clr(sw_clr),
    .aff_we(aff_we), .aff_wdata(bus_wdata[NUM_CPU-1:0]),
    .ack_vec(ack_vec),
    .mask_q(mask_q), .sw_q(sw_q), .pend(pend),
    .aff_q(aff_q), .elig(elig)
  );

  aic_ipi_bank #(
    .NUM_CPU(NUM_CPU), .NUM_IPI(IPI_PER_CPU)
  ) u_ipi (
    .clk(clk), .rst(rst),
    .ipi_set(ipi_set), .ipi_ack(ipi_ack), .ipi_q(ipi_q)
  );

  // per-CPU arbitration
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    aic_pick #(.W(NUM_SRC)) u_pick (
      .req(elig[c]), .found(hw_found[c]),
      .idx(hw_idx[c]), .grant(hw_grant[c])
    );

    always_comb begin
      evt_word[c] = '0;
      ipi_ack[c]  = '0;
      if (ipi_q[c][0]) begin
        evt_word[c][KIND_LSB+:3] = EVT_IPI;
        evt_word[c][15:0]        = 16'd0;
        ipi_ack[c]               = evt_sel[c] ? 2'b01 : 2'b00;
      end else if (ipi_q[c][1]) begin
        evt_word[c][KIND_LSB+:3] = EVT_IPI;
        evt_word[c][15:0]        = 16'd1;
        ipi_ack[c]               = evt_sel[c] ? 2'b10 : 2'b00;
      end else if (hw_found[c]) begin
        evt_word[c][KIND_LSB+:3] = EVT_HW;
        evt_word[c][15:0]        = 16'(hw_idx[c]);
      end
      ack_part[c] = (evt_sel[c] && ipi_q[c] == '0) ? hw_grant[c] : '0;
    end

    assign irq_o[c] = (|elig[c]) | (|ipi_q[c]);
  end

  always_comb begin
    ack_vec = '0;
    for (int c = 0; c < NUM_CPU; c++) ack_vec |= ack_part[c];
  end

  // read mux and registered read data
  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(A_MASK)) rd_next[NUM_SRC-1:0] = mask_q;
    if (bus_addr == ADDR_W'(A_SW))   rd_next[NUM_SRC-1:0] = sw_q;
    if (bus_addr == ADDR_W'(A_PEND)) rd_next[NUM_SRC-1:0] = pend;
    for (int s = 0; s < NUM_SRC; s++)
      if (bus_addr == ADDR_W'(A_AFF_BASE + s)) rd_next[NUM_CPU-1:0] = aff_q[s];
    for (int c = 0; c < NUM_CPU; c++)
      if (bus_addr == ADDR_W'(A_EVT_BASE + c)) rd_next = evt_word[c];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  AST_IPI_BEFORE_HW: assert property (@(posedge clk) disable iff (rst)
    (ipi_ack != '0) |-> (ack_vec == '0)); // R7
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((|evt_sel) && rd_next == '0) |=> ($stable(mask_q) && $stable(ipi_q))); // R8
endmodule

// File: tb/tb_autoack_irq_ctrl.sv
`timescale 1ns/1ps
module tb_autoack_irq_ctrl;
  localparam int NS = 16;
  localparam int NC = 2;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NS-1:0] hw_irq = '0;
  logic [NC-1:0] irq_o;

  always #2.5 clk = ~clk;

  autoack_irq_ctrl #(.NUM_SRC(NS), .NUM_CPU(NC), .ADDR_W(AW), .DATA_W(32)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_irq(hw_irq), .irq_o(irq_o)
  );

  // model
  logic [NS-1:0] m_mask, m_sw, m_hw;
  logic [1:0]    m_aff [NS];
  logic [1:0]    m_ipi [NC];
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(string tag, int a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic set_hw(logic [NS-1:0] v);
    @(negedge clk);
    hw_irq = v; m_hw = v;
    @(negedge clk);
  endtask

  task automatic chk_irq(string tag);
    logic [NC-1:0] exp;
    for (int c = 0; c < NC; c++) begin
      exp[c] = (m_ipi[c] != 2'b00);
      for (int s = 0; s < NS; s++)
        if ((m_hw[s] | m_sw[s]) && !m_mask[s] && m_aff[s][c]) exp[c] = 1'b1;
    end
    chk(tag, 32'(irq_o), 32'(exp));
  endtask

  // expected event and its side effect, then the read
  task automatic do_evt(string tag, int c);
    logic [31:0] exp = '0;
    if (m_ipi[c][0]) begin
      exp = 32'h0002_0000; m_ipi[c][0] = 1'b0;
    end else if (m_ipi[c][1]) begin
      exp = 32'h0002_0001; m_ipi[c][1] = 1'b0;
    end else begin
      for (int s = 0; s < NS; s++)
        if (exp == 0 && (m_hw[s] | m_sw[s]) && !m_mask[s] && m_aff[s][c]) begin
          exp = 32'h0001_0000 | 32'(s);
          m_mask[s] = 1'b1;
        end
    end
    rd_chk(tag, 16 + c, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] pats [5];
    pats[0] = 16'h0001; pats[1] = 16'h8000; pats[2] = 16'h8421;
    pats[3] = 16'hFFFF; pats[4] = 16'h5AA5;
    m_mask = '1; m_sw = '0; m_hw = '0;
    for (int s = 0; s < NS; s++) m_aff[s] = 2'b01;
    for (int c = 0; c < NC; c++) m_ipi[c] = 2'b00;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 rdata", bus_rdata, 0);
    rd_chk("R1 mask", 0, 32'h0000_FFFF);
    rd_chk("R1 sw", 4, 0);
    for (int s = 0; s < NS; s++) rd_chk("R1 aff", 32 + s, 1);
    rd_chk("R1 evt0", 16, 0);
    rd_chk("R1 evt1", 17, 0);

    // R2 software triggers, masked sources stay quiet (R3)
    for (int s = 0; s < NS; s++) begin
      wr(5, 32'(1) << s); m_sw[s] = 1'b1;
      rd_chk("R2 pend", 8, 32'(m_sw | m_hw));
      chk_irq("R3 masked quiet");
    end
    wr(5, 0);
    rd_chk("R2 set zero no effect", 4, 32'h0000_FFFF);
    wr(6, 32'h00FF); m_sw = 16'hFF00;
    rd_chk("R2 clear", 4, 32'h0000_FF00);
    wr(6, 0);
    rd_chk("R2 clear zero no effect", 4, 32'h0000_FF00);
    wr(6, 32'hFFFF); m_sw = '0;

    // R3 mask set/clear sweep
    for (int s = 0; s < NS; s++) begin
      wr(2, 32'(1) << s); m_mask[s] = 1'b0;
      rd_chk("R3 mask clr", 0, 32'(m_mask));
    end
    wr(1, 32'h00F0); m_mask[7:4] = 4'hF;
    rd_chk("R3 mask set", 0, 32'(m_mask));
    wr(1, 32'hFFFF); m_mask = '1;

    // R5 R6 R8 drain patterns on CPU 0
    for (int p = 0; p < 5; p++) begin
      wr(6, 32'hFFFF); wr(5, 32'(pats[p])); m_sw = pats[p];
      wr(2, 32'hFFFF); m_mask = '0;
      chk_irq("R4 pattern raised");
      for (int k = 0; k <= $countones(pats[p]); k++) do_evt("R5 drain", 0);
      rd_chk("R6 mask after drain", 0, 32'(m_mask));
      do_evt("R8 empty read", 0);
      rd_chk("R8 mask unchanged", 0, 32'(m_mask));
      chk_irq("R4 drained");
    end
    wr(6, 32'hFFFF); m_sw = '0;
    wr(1, 32'hFFFF); m_mask = '1;

    // R9 routing
    for (int s = 0; s < NS; s++) begin
      m_aff[s] = (s % 3 == 0) ? 2'b11 : ((s % 2 == 1) ? 2'b10 : 2'b01);
      wr(32 + s, 32'(m_aff[s]));
    end
    rd_chk("R9 aff readback", 32 + 3, 32'(m_aff[3]));
    rd_chk("R9 aff readback", 32 + 4, 32'(m_aff[4]));
    wr(5, 32'hFFFF); m_sw = '1;
    wr(2, 32'hFFFF); m_mask = '0;
    chk_irq("R9 both raised");
    for (int k = 0; k < 20; k++) begin
      do_evt("R9 routed event", k % 2);
      chk_irq("R9 irq");
    end
    wr(6, 32'hFFFF); m_sw = '0;
    wr(1, 32'hFFFF); m_mask = '1;
    for (int s = 0; s < NS; s++) begin
      m_aff[s] = 2'b01; wr(32 + s, 1);
    end

    // R10 level lines re-fire
    set_hw(16'h0220);
    wr(2, 32'hFFFF); m_mask = '0;
    chk_irq("R10 level raised");
    do_evt("R10 first", 0);
    do_evt("R10 second", 0);
    chk_irq("R10 acked quiet");
    wr(2, 32'h0020); m_mask[5] = 1'b0;
    chk_irq("R10 refire");
    do_evt("R10 again", 0);
    set_hw('0);
    wr(2, 32'hFFFF); m_mask = '0;
    chk_irq("R10 line dropped");
    do_evt("R10 none", 0);

    // R7 IPIs
    set_hw(16'h0004);
    wr(32 + 2, 3); m_aff[2] = 2'b11;
    wr(24 + 1, 3); m_ipi[1] = 2'b11;
    chk_irq("R7 ipi raised");
    do_evt("R7 ipi0 first", 1);
    do_evt("R7 ipi1 next", 1);
    do_evt("R7 hw after ipi", 1);
    do_evt("R7 hw masked for cpu0", 0);
    wr(24 + 0, 2); m_ipi[0] = 2'b10;
    chk_irq("R7 ipi only");
    do_evt("R7 ipi1 cpu0", 0);
    chk_irq("R7 ipi cleared");
    do_evt("R7 empty after ipi", 0);
    set_hw('0);

    summary();
  end
endmodule